// File: doc/BRIEF.md
# Composite Sync Regenerator

This block rebuilds a clean, active-low horizontal sync for a progressive PAL-rate video source. A free-running 8-bit divider on the 4 MHz master clock gives one line every 256 cycles (64 µs, 15625 Hz). Each line starts with a 19-cycle low pulse (4.75 µs). The source's own horizontal sync is sampled through a two-flop synchronizer. Each falling edge of that sync reloads the divider with a programmable phase value, so the regenerated pulse can be slid into line with the original. When source edges stop, the divider keeps running at its natural period.

The source's vertical sync goes through the same kind of synchronizer and is merged with the regenerated horizontal sync into an active-low composite sync. Outside the vertical interval the composite output copies the regenerated pulse. While vertical sync is low, the composite output is held low except for a 19-cycle high notch at the start of every line. This gives a display a line-rate reference through the whole vertical interval without double-rate equalization pulses.

A line counter is cleared by each falling vertical edge and advances once per line start. It stops at its largest value if no frame start arrives.

Top module: `csync_regen`

## Requirements
- R1: With no source sync edges, `regen_hs_n` falls once every 256 clock cycles.
- R2: Each regenerated horizontal pulse on `regen_hs_n` stays low for exactly 19 cycles when it is not cut short by a reload.
- R3: A falling edge on `orig_hs_n` that is first sampled low at clock edge k loads the line phase with `phase_ofs` at edge k+2. With a non-zero offset o, `regen_hs_n` next falls 256−o cycles after edge k+2. With offset 0 it falls at edge k+2 itself.
- R4: While `rst` is high, `line_cnt` is 0, the divider sits at the start of a line (`regen_hs_n` low), and `comp_sync_n` equals `regen_hs_n`.
- R5: While the synchronized vertical sync is low, `comp_sync_n` is the inverse of `regen_hs_n`. It is high for the first 19 cycles of each line and low otherwise, so any 768-cycle window inside the interval holds exactly 57 high cycles.
- R6: While the synchronized vertical sync is high, `comp_sync_n` equals `regen_hs_n`.
- R7: `line_cnt` becomes 0 on the clock after a synchronized falling edge of `orig_vs_n`. Otherwise it changes only by +1, once per line start.
- R8: `line_cnt` stays at 511 once it reaches 511, until the next vertical falling edge.
- R9: Vertical sync does not affect `regen_hs_n`. Any 768-cycle window inside the vertical interval holds exactly three falling edges of `regen_hs_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4 MHz master clock |
| rst | input | 1 | Synchronous reset, active high |
| orig_hs_n | input | 1 | Source horizontal sync, active low, asynchronous |
| orig_vs_n | input | 1 | Source vertical sync, active low, asynchronous |
| phase_ofs | input | 8 | Divider value loaded on each source horizontal edge |
| regen_hs_n | output | 1 | Regenerated horizontal sync, active low |
| comp_sync_n | output | 1 | Composite sync, active low |
| line_cnt | output | 9 | Lines since the last frame start, saturating |

## Verification
A behavioural reference is compared against all three outputs on every cycle. It runs under four stimulus patterns:
- **Free-running divider, no source edges.** This separates the natural period and pulse width from any resync effect.
- **Single source edges at two different offsets.** The measured delay shows whether the reload value and the two-cycle synchronizer latency are both right.
- **Steady line-rate source pulses with an offset step partway through.** This shows that locking is stable and that a phase change takes effect at the next edge.
- **Vertical pulse held across several lines.** Counting notch cycles and horizontal falls in a fixed window tells the notch pattern apart from a plain copy or a gated-off horizontal sync.

A long run of lines without a frame start drives the line counter into saturation.

// File: rtl/csr_pkg.sv
package csr_pkg;

    // Synchronized view of one asynchronous sync input.
    typedef struct packed {
        logic level;   // synchronized level (active low sync)
        logic fall;    // one-cycle strobe on a high-to-low transition
    } sync_sig_t;

    localparam int unsigned SYNC_INPUTS = 2;
    localparam int unsigned IDX_HS      = 0;
    localparam int unsigned IDX_VS      = 1;

    // True while the line phase lies inside the pulse window.
    function automatic logic in_window(input int unsigned phase,
                                       input int unsigned width);
        return phase < width;
    endfunction

endpackage

// File: rtl/csr_sync_edge.sv
module csr_sync_edge
    import csr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    output sync_sig_t q
);
    logic meta_q, stab_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b1;
            stab_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= din;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    always_comb begin
        q.level = stab_q;
        q.fall  = prev_q & ~stab_q;
    end
endmodule

// File: rtl/csr_line_div.sv
module csr_line_div #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic [DIV_W-1:0] reload_val,
    output logic [DIV_W-1:0] phase,
    output logic             line_start
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] phase_nx;

    always_comb begin
        phase_nx = reload ? reload_val : phase + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= '0;
            line_start <= 1'b0;
        end else begin
            phase      <= phase_nx;
            line_start <= (phase_nx == '0) && (phase != '0);
        end
    end
endmodule

// File: rtl/csr_line_track.sv
module csr_line_track #(
    parameter int unsigned LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              line_tick,
    output logic [LINE_W-1:0] line
);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;
    localparam logic [LINE_W-1:0] ONE      = LINE_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            line <= '0;
        end else if (frame_start) begin
            line <= '0;
        end else if (line_tick && line != LINE_MAX) begin
            line <= line + ONE;
        end
    end
endmodule

// File: rtl/csync_regen.sv
module csync_regen
    import csr_pkg::*;
#(
    parameter int unsigned DIV_W     = 8,
    parameter int unsigned PULSE_CYC = 19,
    parameter int unsigned LINE_W    = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              orig_hs_n,
    input  logic              orig_vs_n,
    input  logic [DIV_W-1:0]  phase_ofs,
    output logic              regen_hs_n,
    output logic              comp_sync_n,
    output logic [LINE_W-1:0] line_cnt
);
    logic [SYNC_INPUTS-1:0] raw_in;
    sync_sig_t              sy [SYNC_INPUTS];

    assign raw_in[IDX_HS] = orig_hs_n;
    assign raw_in[IDX_VS] = orig_vs_n;

    for (genvar g = 0; g < SYNC_INPUTS; g++) begin : g_sync
        csr_sync_edge u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw_in[g]),
            .q   (sy[g])
        );
    end

    logic             hs_fall, vs_fall, vs_low;
    logic [DIV_W-1:0] div_cnt;
    logic             line_start;
    logic             pulse_on;

    assign hs_fall = sy[IDX_HS].fall;
    assign vs_fall = sy[IDX_VS].fall;
    assign vs_low  = ~sy[IDX_VS].level;

    csr_line_div #(.DIV_W(DIV_W)) u_div (
        .clk        (clk),
        .rst        (rst),
        .reload     (hs_fall),
        .reload_val (phase_ofs),
        .phase      (div_cnt),
        .line_start (line_start)
    );

    csr_line_track #(.LINE_W(LINE_W)) u_track (
        .clk         (clk),
        .rst         (rst),
        .frame_start (vs_fall),
        .line_tick   (line_start),
        .line        (line_cnt)
    );

    assign pulse_on    = in_window(int'(div_cnt), PULSE_CYC);
    assign regen_hs_n  = ~pulse_on;
    assign comp_sync_n = vs_low ? pulse_on : ~pulse_on;
endmodule

// File: rtl/csync_regen_chk.sv
module csync_regen_chk #(
    parameter int unsigned DIV_W  = 8,
    parameter int unsigned LINE_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              hs_fall,
    input logic              vs_fall,
    input logic              vs_low,
    input logic [DIV_W-1:0]  div_cnt,
    input logic [DIV_W-1:0]  phase_ofs,
    input logic              regen_hs_n,
    input logic              comp_sync_n,
    input logic [LINE_W-1:0] line_cnt
);
    localparam logic [LINE_W-1:0] LMAX  = '1;
    localparam logic [LINE_W-1:0] LONE  = LINE_W'(1);
    localparam logic [DIV_W-1:0]  DONE  = DIV_W'(1);

    // R1
    div_step_chk: assert property (@(posedge clk) disable iff (rst)
        !hs_fall |=> div_cnt == $past(div_cnt) + DONE);

    // R3
    div_reload_chk: assert property (@(posedge clk) disable iff (rst)
        hs_fall |=> div_cnt == $past(phase_ofs));

    // R5
    notch_chk: assert property (@(posedge clk) disable iff (rst)
        vs_low |-> comp_sync_n != regen_hs_n);

    // R6
    pass_chk: assert property (@(posedge clk) disable iff (rst)
        !vs_low |-> comp_sync_n == regen_hs_n);

    // R7
    frame_clear_chk: assert property (@(posedge clk) disable iff (rst)
        vs_fall |=> line_cnt == '0);

    // R7
    line_step_chk: assert property (@(posedge clk) disable iff (rst)
        !vs_fall |=> (line_cnt == $past(line_cnt)) ||
                     (line_cnt == $past(line_cnt) + LONE));

    // R8
    line_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (line_cnt == LMAX && !vs_fall) |=> line_cnt == LMAX);
endmodule

bind csync_regen csync_regen_chk #(.DIV_W(DIV_W), .LINE_W(LINE_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .hs_fall     (hs_fall),
    .vs_fall     (vs_fall),
    .vs_low      (vs_low),
    .div_cnt     (div_cnt),
    .phase_ofs   (phase_ofs),
    .regen_hs_n  (regen_hs_n),
    .comp_sync_n (comp_sync_n),
    .line_cnt    (line_cnt)
);

// File: tb/csync_regen_tb.sv
module csync_regen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       orig_hs_n = 1'b1;
    logic       orig_vs_n = 1'b1;
    logic [7:0] phase_ofs = 8'd0;
    logic       regen_hs_n, comp_sync_n;
    logic [8:0] line_cnt;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    csync_regen dut_i (
        .clk         (clk),
        .rst         (rst),
        .orig_hs_n   (orig_hs_n),
        .orig_vs_n   (orig_vs_n),
        .phase_ofs   (phase_ofs),
        .regen_hs_n  (regen_hs_n),
        .comp_sync_n (comp_sync_n),
        .line_cnt    (line_cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: delayed input samples and a line phase counter.
    int hq[$] = '{1, 1, 1};
    int vq[$] = '{1, 1, 1};
    int m_phase = 0;
    int m_line  = 0;
    bit m_start = 0;

    always @(posedge clk) begin
        if (rst) begin
            hq = '{1, 1, 1};
            vq = '{1, 1, 1};
            m_phase = 0;
            m_line = 0;
            m_start = 0;
        end else begin
            bit hfall, vfall;
            int prev;
            hfall = (hq[2] == 1) && (hq[1] == 0);
            vfall = (vq[2] == 1) && (vq[1] == 0);
            prev = m_phase;
            m_phase = hfall ? int'(phase_ofs) : (m_phase + 1) % 256;
            if (vfall) m_line = 0;
            else if (m_start && m_line < 511) m_line++;
            m_start = (m_phase == 0) && (prev != 0);
            hq.push_front(int'(orig_hs_n)); void'(hq.pop_back());
            vq.push_front(int'(orig_vs_n)); void'(vq.pop_back());
        end
    end

    // Every-cycle comparison, sampled on the falling edge.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            int e_hs, e_cs;
            bit vl;
            e_hs = (m_phase >= 19) ? 1 : 0;
            vl = (vq[1] == 0);
            e_cs = vl ? ((m_phase < 19) ? 1 : 0) : e_hs;
            check(regen_hs_n == e_hs[0], "R3 regen_hs_n", int'(regen_hs_n), e_hs);
            check(comp_sync_n == e_cs[0], vl ? "R5 comp_sync_n" : "R6 comp_sync_n",
                  int'(comp_sync_n), e_cs);
            check(int'(line_cnt) == m_line, "R7 line_cnt", int'(line_cnt), m_line);
        end
    end

    // Free-run period and width measurement.
    bit measure_en = 0;
    int cyc = 0;
    int last_fall = -1;
    bit prev_hs = 0;
    always @(negedge clk) begin
        cyc++;
        if (measure_en) begin
            if (prev_hs && !regen_hs_n) begin
                if (last_fall >= 0)
                    check(cyc - last_fall == 256, "R1 period", cyc - last_fall, 256);
                last_fall = cyc;
            end
            if (!prev_hs && regen_hs_n && last_fall >= 0)
                check(cyc - last_fall == 19, "R2 width", cyc - last_fall, 19);
        end
        prev_hs = regen_hs_n;
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic lines(input int n);
        for (int i = 0; i < n; i++) begin
            orig_hs_n = 1'b0;
            idle(20);
            orig_hs_n = 1'b1;
            idle(236);
        end
    endtask

    task automatic phase_probe(input int ofs);
        int got;
        bit p;
        got = -1;
        phase_ofs = ofs[7:0];
        @(negedge clk);
        orig_hs_n = 1'b0;
        p = regen_hs_n;
        for (int n = 1; n <= 300; n++) begin
            @(negedge clk);
            if (n == 20) orig_hs_n = 1'b1;
            if (n >= 4 && p && !regen_hs_n && got < 0) got = n;
            p = regen_hs_n;
        end
        check(got == 3 + 256 - ofs, "R3 phase", got, 3 + 256 - ofs);
    endtask

    initial begin
        int hi_cnt, falls;
        bit p;
        idle(3);
        check(line_cnt == 9'd0, "R4 reset line_cnt", int'(line_cnt), 0);
        check(regen_hs_n == 1'b0, "R4 reset regen_hs_n", int'(regen_hs_n), 0);
        check(comp_sync_n == regen_hs_n, "R4 reset comp_sync_n", int'(comp_sync_n), int'(regen_hs_n));
        idle(2);
        rst = 1'b0;

        measure_en = 1;
        idle(1100);
        measure_en = 0;

        phase_probe(40);
        phase_probe(200);

        phase_ofs = 8'd0;
        lines(10);
        phase_ofs = 8'd100;
        lines(8);

        hi_cnt = 0;
        falls = 0;
        fork
            lines(12);
            begin
                idle(512);
                orig_vs_n = 1'b0;
                p = regen_hs_n;
                for (int i = 1; i <= 800; i++) begin
                    @(negedge clk);
                    if (i >= 3 && i <= 770) begin
                        if (comp_sync_n) hi_cnt++;
                        if (p && !regen_hs_n) falls++;
                    end
                    p = regen_hs_n;
                end
                orig_vs_n = 1'b1;
            end
        join
        check(hi_cnt == 57, "R5 notch cycles", hi_cnt, 57);
        check(falls == 3, "R9 falls in vertical interval", falls, 3);

        lines(515);
        check(line_cnt == 9'd511, "R8 saturation", int'(line_cnt), 511);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(195000 * 4);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule